// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM Timer

This block produces one pulse-width-modulated output from a free-running 32-bit up-counter. The counter is compared against an active period value and an active compare value. Software programs the block through a small word-addressed register map. When the counter is stopped, it writes the active pair directly. While the counter is running, it writes a shadow pair instead. The shadow pair is copied into the active pair only when the count wraps, so the period in progress always finishes with the settings it started with.

A 16-bit control word holds four settings:

- A run bit starts and stops the counter.
- A mode bit enables the output. When the mode bit is clear, the output is held low.
- A polarity bit chooses whether the compare count sets the high part or the low part of each period.
- A two-bit sync field is stored and read back. No sync source exists, so it never reloads the counter.

The counter is sequenced by a two-state machine:

- `ST_HALT`: the count is frozen.
- `ST_RUN`: the count advances.
- Transition START (`ST_HALT` to `ST_RUN`): taken on the clock after the run bit is seen set.
- Transition STOP (`ST_RUN` to `ST_HALT`): taken on the clock after the run bit is seen clear.

Top module: `apwm_shadow`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is low. The counter is at 0 and in `ST_HALT`.
- R2: Reads are combinational and depend only on `bus_addr`:
  - 0x08 returns the active period.
  - 0x0C returns the active compare.
  - 0x10 returns the shadow period.
  - 0x14 returns the shadow compare.
  - 0x2A returns the control word zero-extended. Only bits 15:0 of a control write are kept.
  - Any other offset reads 0.
- R3: One clock after control bit 4 (run) is seen set, the state is `ST_RUN`. In `ST_RUN` the count steps by one per clock. On the clock after the count reaches or passes the active period P, it returns to 0, so one period lasts P+1 clocks. In `ST_HALT` the count holds.
- R4: With control bit 9 (mode) at 1 and bit 10 (polarity) at 0, `pwm_out` is high while count < compare and low otherwise. A compare greater than or equal to the period gives a constantly high output.
- R5: With polarity bit 10 at 1, the waveform of R4 is inverted, so the compare count sets the low part of the period.
- R6: While control bit 9 is 0, `pwm_out` is low whatever the count, compare or polarity.
- R7: A write to the shadow period or shadow compare sets a pending flag. The active pair is unchanged until the wrap clock. On the wrap clock both shadow values move into the active pair and the flag clears.
- R8: A wrap with no pending flag leaves the active pair unchanged.
- R9: A write to 0x08 or 0x0C updates the active value on that clock, including while running.
- R10: Control bits 7:6 are stored and read back, and they have no effect on counting or on the output.
- R11: A control write changes no other register.
- R12: The smallest setting, period 1 with compare 1, runs a two-clock period and gives a constant high output when polarity is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register map |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is sampled on every clock under several compare/period pairs:
- A compare below the period produces a split waveform.
- A compare above the period produces constant high.
- Period 1 with compare 1 exercises the smallest setting.

Each of these is repeated with polarity inverted and with the mode bit off. Comparing the results separates the mode gate from the polarity inversion.

Shadow writes are issued at an arbitrary phase mid-period. Reads taken before the wrap show the old active values, and the waveform changes only after the wrap; together these distinguish a transfer at the boundary from an early one. Direct active writes followed by several wraps show that a cleared pending flag is not reapplied. Stopping the counter with the mode bit still set shows that the count is frozen.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    // Register offsets (software-visible, decoded by the register file)
    localparam logic [7:0] OFS_PER_ACT = 8'h08;
    localparam logic [7:0] OFS_CMP_ACT = 8'h0C;
    localparam logic [7:0] OFS_PER_SHD = 8'h10;
    localparam logic [7:0] OFS_CMP_SHD = 8'h14;
    localparam logic [7:0] OFS_CTRL    = 8'h2A;

    // Control word bit positions
    localparam int CB_RUN     = 4;
    localparam int CB_SYNC_LO = 6;
    localparam int CB_SYNC_HI = 7;
    localparam int CB_MODE    = 9;
    localparam int CB_POL     = 10;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/apwm_regfile.sv
module apwm_regfile
    import apwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wrap,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] per_act,
    output logic [DW-1:0] cmp_act,
    output logic [DW-1:0] per_shd,
    output logic [DW-1:0] cmp_shd,
    output logic          pending,
    output logic [CW-1:0] ctrl
);

    localparam int PAD_W = DW - CW;

    // Boundary transfer first, bus write second: a bus write in the same
    // clock overrides the transfer for the register it addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= '0;
            cmp_act <= '0;
            per_shd <= '0;
            cmp_shd <= '0;
            pending <= 1'b0;
            ctrl    <= '0;
        end else begin
            if (wrap && pending) begin
                per_act <= per_shd;
                cmp_act <= cmp_shd;
                pending <= 1'b0;
            end
            if (wr_en) begin
                case (addr)
                    AW'(OFS_PER_ACT): per_act <= wdata;
                    AW'(OFS_CMP_ACT): cmp_act <= wdata;
                    AW'(OFS_PER_SHD): begin
                        per_shd <= wdata;
                        pending <= 1'b1;
                    end
                    AW'(OFS_CMP_SHD): begin
                        cmp_shd <= wdata;
                        pending <= 1'b1;
                    end
                    AW'(OFS_CTRL):    ctrl <= wdata[CW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            AW'(OFS_PER_ACT): rdata = per_act;
            AW'(OFS_CMP_ACT): rdata = cmp_act;
            AW'(OFS_PER_SHD): rdata = per_shd;
            AW'(OFS_CMP_SHD): rdata = cmp_shd;
            AW'(OFS_CTRL):    rdata = {{PAD_W{1'b0}}, ctrl};
            default:          rdata = '0;
        endcase
    end

endmodule

// File: rtl/apwm_timebase.sv
module apwm_timebase
    import apwm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic [DW-1:0] per_act,
    output logic [DW-1:0] cnt,
    output logic          running,
    output logic          wrap
);

    cnt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Transitions: START (HALT->RUN) and STOP (RUN->HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_HALT;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        running = (state_q == ST_RUN);
        wrap    = running && (cnt >= per_act);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (running) cnt <= wrap ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/apwm_wave.sv
module apwm_wave #(
    parameter int DW = 32
) (
    input  logic          mode,
    input  logic          pol,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] per_act,
    input  logic [DW-1:0] cmp_act,
    output logic          pwm_out
);

    logic hi_phase;

    always_comb begin
        hi_phase = (cmp_act >= per_act) || (cnt < cmp_act);
        pwm_out  = mode & (hi_phase ^ pol);
    end

endmodule

// File: rtl/apwm_shadow.sv
module apwm_shadow
    import apwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          pwm_out
);

    logic [DW-1:0] per_act, cmp_act, per_shd, cmp_shd, cnt;
    logic [CW-1:0] ctrl;
    logic          pending, running, wrap;

    apwm_regfile #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wrap    (wrap),
        .rdata   (bus_rdata),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .per_shd (per_shd),
        .cmp_shd (cmp_shd),
        .pending (pending),
        .ctrl    (ctrl)
    );

    apwm_timebase #(.DW(DW)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (ctrl[CB_RUN]),
        .per_act (per_act),
        .cnt     (cnt),
        .running (running),
        .wrap    (wrap)
    );

    apwm_wave #(.DW(DW)) u_wave (
        .mode    (ctrl[CB_MODE]),
        .pol     (ctrl[CB_POL]),
        .cnt     (cnt),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/apwm_shadow_chk.sv
module apwm_shadow_chk
    import apwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          pwm_out,
    input logic [DW-1:0] cnt,
    input logic          running,
    input logic          wrap,
    input logic [DW-1:0] per_act,
    input logic [DW-1:0] cmp_act,
    input logic [DW-1:0] per_shd,
    input logic [DW-1:0] cmp_shd,
    input logic          pending,
    input logic [CW-1:0] ctrl
);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(cnt));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt >= per_act) |=> (cnt == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt < per_act) |=> (cnt == $past(cnt) + 1'b1));

    p_pol0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_MODE] && !ctrl[CB_POL] && cnt < cmp_act) |-> pwm_out);

    p_mode_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_MODE] |-> !pwm_out);

    p_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pending && !bus_wr) |=>
            (per_act == $past(per_shd) && cmp_act == $past(cmp_shd) && !pending));

    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !bus_wr) |=> ($stable(per_act) && $stable(cmp_act)));

endmodule

bind apwm_shadow apwm_shadow_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .pwm_out (pwm_out),
    .cnt     (cnt),
    .running (running),
    .wrap    (wrap),
    .per_act (per_act),
    .cmp_act (cmp_act),
    .per_shd (per_shd),
    .cmp_shd (cmp_shd),
    .pending (pending),
    .ctrl    (ctrl)
);

// File: tb/sim_apwm_shadow.sv
module sim_apwm_shadow;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    always #2 clk = ~clk;

    apwm_shadow u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    typedef struct {
        string       req;
        logic        exp_pwm;
        logic [31:0] exp_rd;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sample_ev;
    int       n_checks = 0;
    int       n_errors = 0;
    bit       done = 1'b0;

    // Expectation state, built from the requirements
    bit          m_run;
    logic [31:0] m_cnt, m_pa, m_ca, m_ps, m_cs;
    bit          m_pend;
    logic [15:0] m_ctrl;

    function automatic logic exp_pwm();
        logic hi;
        hi = (m_ca >= m_pa) || (m_cnt < m_ca);
        return m_ctrl[9] & (hi ^ m_ctrl[10]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h08:   return m_pa;
            8'h0C:   return m_ca;
            8'h10:   return m_ps;
            8'h14:   return m_cs;
            8'h2A:   return {16'h0, m_ctrl};
            default: return 32'h0;
        endcase
    endfunction

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (pwm_out !== it.exp_pwm || bus_rdata !== it.exp_rd) begin
                    n_errors++;
                    $display("FAIL %s: pwm_out=%0b rdata=%h expected pwm_out=%0b rdata=%h",
                             it.req, pwm_out, bus_rdata, it.exp_pwm, it.exp_rd);
                end
            end
        end
    end

    // Driver: one bus cycle, optional expectation, then expectation-state update
    task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input bit chk, input string req);
        bit          bnd;
        logic [31:0] n_cnt;
        logic [15:0] old_ctrl;
        sb_item_t    it;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        if (chk) begin
            it.req = req; it.exp_pwm = exp_pwm(); it.exp_rd = exp_rd(a);
            sb_q.push_back(it);
            -> sample_ev;
        end
        @(posedge clk);
        old_ctrl = m_ctrl;
        bnd   = m_run && (m_cnt >= m_pa);
        n_cnt = m_run ? (bnd ? 32'h0 : m_cnt + 1) : m_cnt;
        if (bnd && m_pend) begin
            m_pa = m_ps; m_ca = m_cs; m_pend = 1'b0;
        end
        if (wr) begin
            case (a)
                8'h08: m_pa = d;
                8'h0C: m_ca = d;
                8'h10: begin m_ps = d; m_pend = 1'b1; end
                8'h14: begin m_cs = d; m_pend = 1'b1; end
                8'h2A: m_ctrl = d[15:0];
                default: ;
            endcase
        end
        m_run = old_ctrl[4];
        m_cnt = n_cnt;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h08, 32'h0, 1'b1, req);
    endtask

    task automatic read_all(input string req);
        cyc(1'b0, 8'h08, 32'h0, 1'b1, req);
        cyc(1'b0, 8'h0C, 32'h0, 1'b1, req);
        cyc(1'b0, 8'h10, 32'h0, 1'b1, req);
        cyc(1'b0, 8'h14, 32'h0, 1'b1, req);
        cyc(1'b0, 8'h2A, 32'h0, 1'b1, req);
        cyc(1'b0, 8'h04, 32'h0, 1'b1, req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        m_run = 0; m_cnt = 0; m_pa = 0; m_ca = 0; m_ps = 0; m_cs = 0;
        m_pend = 0; m_ctrl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and the output
        read_all("R1");

        // R9: direct active writes while halted; R2: readback
        cyc(1'b1, 8'h08, 32'd4, 1'b1, "R9");
        cyc(1'b1, 8'h0C, 32'd2, 1'b1, "R9");
        read_all("R2");
        // R2: upper half of a control write is dropped
        cyc(1'b1, 8'h2A, 32'hFFFF_0000, 1'b1, "R2");
        cyc(1'b0, 8'h2A, 32'h0, 1'b1, "R2");
        // R11: control write leaves the other registers alone
        cyc(1'b0, 8'h08, 32'h0, 1'b1, "R11");
        cyc(1'b0, 8'h0C, 32'h0, 1'b1, "R11");

        // R4 / R3: mode on, run on, sync field 11 (R10)
        cyc(1'b1, 8'h2A, 32'h0000_02D0, 1'b1, "R4");
        idle(16, "R4");
        cyc(1'b0, 8'h2A, 32'h0, 1'b1, "R10");

        // R7: shadow writes mid-period, transfer only at the wrap
        cyc(1'b1, 8'h10, 32'd6, 1'b1, "R7");
        cyc(1'b1, 8'h14, 32'd3, 1'b1, "R7");
        cyc(1'b0, 8'h08, 32'h0, 1'b1, "R7");
        idle(20, "R7");
        cyc(1'b0, 8'h08, 32'h0, 1'b1, "R7");
        cyc(1'b0, 8'h0C, 32'h0, 1'b1, "R7");

        // R9 then R8: direct writes while running, no stale shadow reapplied
        cyc(1'b1, 8'h08, 32'd3, 1'b1, "R9");
        cyc(1'b1, 8'h0C, 32'd1, 1'b1, "R9");
        idle(12, "R8");
        cyc(1'b0, 8'h08, 32'h0, 1'b1, "R8");
        cyc(1'b0, 8'h0C, 32'h0, 1'b1, "R8");

        // R5: inverted polarity
        cyc(1'b1, 8'h2A, 32'h0000_06D0, 1'b1, "R5");
        idle(10, "R5");

        // R6: mode off forces low
        cyc(1'b1, 8'h2A, 32'h0000_04D0, 1'b1, "R6");
        idle(6, "R6");

        // R3: run off with mode on, count frozen so output is static
        cyc(1'b1, 8'h2A, 32'h0000_0200, 1'b1, "R3");
        idle(8, "R3");

        // R10: sync field 00 behaves the same
        cyc(1'b1, 8'h2A, 32'h0000_0210, 1'b1, "R10");
        idle(10, "R10");
        cyc(1'b0, 8'h2A, 32'h0, 1'b1, "R10");

        // R4: compare above period gives constant high
        cyc(1'b1, 8'h08, 32'd3, 1'b1, "R4");
        cyc(1'b1, 8'h0C, 32'd7, 1'b1, "R4");
        idle(8, "R4");

        // R12: smallest setting
        cyc(1'b1, 8'h08, 32'd1, 1'b1, "R12");
        cyc(1'b1, 8'h0C, 32'd1, 1'b1, "R12");
        idle(8, "R12");
        cyc(1'b1, 8'h2A, 32'h0000_0610, 1'b1, "R12");
        idle(6, "R12");

        cyc(1'b0, 8'h00, 32'h0, 1'b0, "");
        done = 1'b1;
        #1;
        finish_run();
    end

endmodule